// File: doc/BRIEF.md
# Display Phase and Line-Interrupt Controller

This block tracks where a video display processor stands within a frame: blanked (IDLE), on the single warm-up line that comes just before the picture (PREP), or drawing picture lines (LIVE). It follows the vertical line number that an external line counter reports on each line-advance strobe. It also follows the two mode-select bits, which are written as a group. When neither mode is selected the controller holds the display blanked. When a later mode write selects a valid mode again, it recovers the phase from the current line.

The same strobe runs a horizontal-interrupt down-counter. The counter is reloaded on every line outside the LIVE phase. During LIVE lines it counts down, and when it has reached zero a pending flag is raised and the counter is reloaded. The pending flag stays set until software acknowledges it. The outputs are the phase, a display-active flag and its inverse, the vertical-blank status bit. Every state element is registered, so each strobe takes effect one clock after it is sampled. The display-active and vblank outputs also follow the display-enable input with no clock delay.

States: IDLE (code 0), PREP (code 1), LIVE (code 2). Transitions:
- PROMOTE: PREP to LIVE on any line advance.
- RETIRE: LIVE to IDLE when the advanced line equals the inactive-start line.
- ARM: IDLE to PREP when the advanced line is the first active line.
- KILL: any state to IDLE on a mode write that selects neither mode.
- RESUME: IDLE to LIVE or PREP on a mode write that selects a valid mode.

Top module: `dpl_phase_ctrl`

## Requirements
- R1: Reset sets the phase to IDLE (code 0), clears the pending flag and sets the interrupt counter to zero. With a zero counter, the first line advance taken in LIVE raises pending.
- R2: The phase output uses 2-bit codes: IDLE=0, PREP=1, LIVE=2. Code 3 never appears.
- R3: On a line advance, PREP becomes LIVE (PROMOTE).
- R4: In LIVE, a line advance whose line number equals the inactive-start line moves the phase to IDLE (RETIRE).
- R5: In IDLE, a line advance onto the first active line moves the phase to PREP (ARM). The first active line is 0x1FF when mode 5 is selected, which takes precedence over mode 4. It is 0 when only mode 4 is selected. With neither mode selected, no line arms the phase.
- R6: A mode write with both mode-select bits clear forces IDLE (KILL).
- R7: A mode write with a valid mode while in IDLE sets LIVE if the line is below inactive-start. Otherwise, with mode 5 only, it sets PREP if the line is 0x1FF. In any other case the phase stays IDLE (RESUME).
- R8: The display-active output is 1 exactly when the phase is not IDLE and display enable is 1. The vblank output (status bit 3) is its inverse.
- R9: On a line advance taken outside LIVE, after any PROMOTE, the counter loads the reload value.
- R10: On a line advance taken in LIVE, a non-zero counter decrements. A zero counter raises pending and reloads, so pending rises once every reload+1 LIVE lines.
- R11: An acknowledge pulse clears pending. A raise in the same cycle wins over the acknowledge.
- R12: When a line advance and a mode write arrive in the same cycle, the line advance is applied first and the mode-write rules then act on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_adv | input | 1 | One-cycle strobe: the line number has just advanced |
| line_num | input | 9 | Current line number |
| inactive_start | input | 9 | First blanked line after the picture |
| mode4_sel | input | 1 | Mode-4 select bit |
| mode5_sel | input | 1 | Mode-5 select bit |
| disp_en | input | 1 | Display enable |
| irq_reload | input | 8 | Reload value for the line-interrupt counter |
| mode_wr | input | 1 | One-cycle strobe: mode register written |
| irq_ack | input | 1 | One-cycle strobe: acknowledge the pending interrupt |
| phase | output | 2 | Current phase code |
| disp_active | output | 1 | Display is drawing |
| vblank | output | 1 | Vertical-blank status bit |
| irq_pending | output | 1 | Line interrupt pending |

## Verification
The assertions check on every cycle the transitions that hold in isolation. These are: PREP promotes on a line advance, KILL lands in IDLE, IDLE holds without a strobe, the counter reloads outside LIVE, a zero count in LIVE raises pending, an acknowledge clears it, and IDLE always reads as vblank. Only the bench scenarios can show the frame-level behaviour. This covers the pending cadence over several LIVE lines and the arming line chosen by each mode pair. It also covers RESUME, which depends on where the line sits relative to inactive-start, and the ordering rule when a line advance and a mode write coincide.

// File: rtl/dpl_pkg.sv
package dpl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PREP = 2'd1,
        PH_LIVE = 2'd2
    } phase_e;

endpackage

// File: rtl/dpl_phase_fsm.sv
module dpl_phase_fsm
    import dpl_pkg::*;
#(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_adv,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] inactive_start,
    input  logic              mode4_sel,
    input  logic              mode5_sel,
    input  logic              mode_wr,
    output phase_e            phase,
    output logic              adv_live
);

    localparam logic [LINE_W-1:0] LAST_LINE  = {LINE_W{1'b1}};
    localparam logic [LINE_W-1:0] FIRST_LINE = '0;

    phase_e phase_q;
    phase_e promoted;
    phase_e after_line;
    phase_e phase_d;
    logic   mode_valid;
    logic   arm_hit;
    logic   below_start;

    assign mode_valid  = mode4_sel | mode5_sel;
    assign below_start = (line_num < inactive_start);

    // First active line: mode 5 wins; neither mode arms nothing
    always_comb begin
        if (mode5_sel) begin
            arm_hit = (line_num == LAST_LINE);
        end else if (mode4_sel) begin
            arm_hit = (line_num == FIRST_LINE);
        end else begin
            arm_hit = 1'b0;
        end
    end

    // PROMOTE happens before anything else on a line advance
    always_comb begin
        promoted = phase_q;
        if (line_adv && phase_q == PH_PREP) begin
            promoted = PH_LIVE;
        end
    end

    assign adv_live = (promoted == PH_LIVE);

    // Line-advance transitions (RETIRE / ARM)
    always_comb begin
        after_line = phase_q;
        if (line_adv) begin
            unique case (promoted)
                PH_IDLE: after_line = arm_hit ? PH_PREP : PH_IDLE;
                PH_PREP: after_line = PH_LIVE;
                PH_LIVE: after_line = (line_num == inactive_start) ? PH_IDLE : PH_LIVE;
                default: after_line = PH_IDLE;
            endcase
        end
    end

    // Mode-write transitions (KILL / RESUME), applied after the line advance
    always_comb begin
        phase_d = after_line;
        if (mode_wr) begin
            if (!mode_valid) begin
                phase_d = PH_IDLE;
            end else begin
                unique case (after_line)
                    PH_IDLE: begin
                        if (below_start) begin
                            phase_d = PH_LIVE;
                        end else if (mode5_sel && line_num == LAST_LINE) begin
                            phase_d = PH_PREP;
                        end else begin
                            phase_d = PH_IDLE;
                        end
                    end
                    PH_PREP: phase_d = PH_PREP;
                    PH_LIVE: phase_d = PH_LIVE;
                    default: phase_d = PH_IDLE;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase = phase_q;

    assert_phase_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != 2'd3);

    assert_prep_promote_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PREP && line_adv && !mode_wr && line_num != inactive_start)
        |=> phase_q == PH_LIVE);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !line_adv && !mode_wr) |=> phase_q == PH_IDLE);

    assert_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !mode4_sel && !mode5_sel) |=> phase_q == PH_IDLE);

endmodule

// File: rtl/dpl_line_irq.sv
module dpl_line_irq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_adv,
    input  logic             adv_live,
    input  logic [CNT_W-1:0] irq_reload,
    input  logic             irq_ack,
    output logic             irq_pending
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             raise;
    logic             pend_q;

    always_comb begin
        cnt_d = cnt_q;
        raise = 1'b0;
        if (line_adv) begin
            if (!adv_live) begin
                cnt_d = irq_reload;
            end else if (cnt_q != CNT_ZERO) begin
                cnt_d = cnt_q - CNT_ONE;
            end else begin
                raise = 1'b1;
                cnt_d = irq_reload;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_ZERO;
            pend_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (raise) begin
                pend_q <= 1'b1;
            end else if (irq_ack) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign irq_pending = pend_q;

    assert_idle_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_adv && !adv_live) |=> cnt_q == $past(irq_reload));

    assert_zero_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_adv && adv_live && cnt_q == CNT_ZERO) |=> irq_pending);

    assert_ack_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !line_adv) |=> !irq_pending);

    assert_pend_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !irq_ack) |=> irq_pending);

endmodule

// File: rtl/dpl_status.sv
module dpl_status
    import dpl_pkg::*;
(
    input  phase_e phase,
    input  logic   disp_en,
    output logic   disp_active,
    output logic   vblank
);

    always_comb begin
        unique case (phase)
            PH_IDLE: disp_active = 1'b0;
            PH_PREP: disp_active = disp_en;
            PH_LIVE: disp_active = disp_en;
            default: disp_active = 1'b0;
        endcase
        vblank = ~disp_active;
    end

endmodule

// File: rtl/dpl_phase_ctrl.sv
module dpl_phase_ctrl
    import dpl_pkg::*;
#(
    parameter int LINE_W = 9,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_adv,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] inactive_start,
    input  logic              mode4_sel,
    input  logic              mode5_sel,
    input  logic              disp_en,
    input  logic [CNT_W-1:0]  irq_reload,
    input  logic              mode_wr,
    input  logic              irq_ack,
    output logic [1:0]        phase,
    output logic              disp_active,
    output logic              vblank,
    output logic              irq_pending
);

    phase_e phase_s;
    logic   adv_live_s;

    dpl_phase_fsm #(.LINE_W(LINE_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_adv       (line_adv),
        .line_num       (line_num),
        .inactive_start (inactive_start),
        .mode4_sel      (mode4_sel),
        .mode5_sel      (mode5_sel),
        .mode_wr        (mode_wr),
        .phase          (phase_s),
        .adv_live       (adv_live_s)
    );

    dpl_line_irq #(.CNT_W(CNT_W)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_adv    (line_adv),
        .adv_live    (adv_live_s),
        .irq_reload  (irq_reload),
        .irq_ack     (irq_ack),
        .irq_pending (irq_pending)
    );

    dpl_status u_status (
        .phase       (phase_s),
        .disp_en     (disp_en),
        .disp_active (disp_active),
        .vblank      (vblank)
    );

    assign phase = phase_s;

    assert_idle_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_s == PH_IDLE) |-> vblank);

endmodule

// File: tb/dpl_phase_ctrl_bench.sv
module dpl_phase_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_adv = 1'b0;
    logic [8:0] line_num = '0;
    logic [8:0] inactive_start = 9'd8;
    logic       mode4_sel = 1'b0;
    logic       mode5_sel = 1'b0;
    logic       disp_en = 1'b1;
    logic [7:0] irq_reload = '0;
    logic       mode_wr = 1'b0;
    logic       irq_ack = 1'b0;
    logic [1:0] phase;
    logic       disp_active, vblank, irq_pending;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // reference state
    int m_ph;
    int m_cnt;
    bit m_pend;

    always #10 clk = ~clk;

    dpl_phase_ctrl u_dpl_phase_ctrl (
        .clk(clk), .rst_n(rst_n), .line_adv(line_adv), .line_num(line_num),
        .inactive_start(inactive_start), .mode4_sel(mode4_sel), .mode5_sel(mode5_sel),
        .disp_en(disp_en), .irq_reload(irq_reload), .mode_wr(mode_wr), .irq_ack(irq_ack),
        .phase(phase), .disp_active(disp_active), .vblank(vblank), .irq_pending(irq_pending)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (line %0d)", tag, act, exp, line_num);
        end
    endtask

    // Reference update from the requirements, one sampled clock edge
    task automatic model_edge(input bit adv, input bit wr, input bit ack);
        int  p = m_ph;
        bit  up = 0;
        if (adv) begin
            if (p == 1) p = 2;                       // R3
            if (p != 2) m_cnt = irq_reload;          // R9
            else if (m_cnt == 0) begin up = 1; m_cnt = irq_reload; end  // R10
            else m_cnt = m_cnt - 1;
            if (p == 2) begin
                if (line_num == inactive_start) p = 0;  // R4
            end else if (p == 0) begin
                if (mode5_sel) begin if (line_num == 9'h1FF) p = 1; end  // R5
                else if (mode4_sel) begin if (line_num == 9'h000) p = 1; end
            end
        end
        if (wr) begin                                 // R12: after the advance
            if (!mode4_sel && !mode5_sel) p = 0;      // R6
            else if (p == 0) begin                    // R7
                if (line_num < inactive_start) p = 2;
                else if (mode5_sel && line_num == 9'h1FF) p = 1;
            end
        end
        if (up) m_pend = 1;                            // R11: raise wins
        else if (ack) m_pend = 0;
        m_ph = p;
    endtask

    task automatic compare_all();
        bit exp_act = (m_ph != 0) && disp_en;
        check("R2 phase", phase, m_ph);
        check("R10 pending", irq_pending, m_pend);
        check("R8 disp_active", disp_active, exp_act);
        check("R8 vblank", vblank, !exp_act);
    endtask

    task automatic step(input bit adv, input int ln, input bit wr, input bit ack);
        @(negedge clk);
        line_adv = adv; line_num = ln[8:0]; mode_wr = wr; irq_ack = ack;
        @(posedge clk);
        model_edge(adv, wr, ack);
        #1;
        line_adv = 1'b0; mode_wr = 1'b0; irq_ack = 1'b0;
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        line_adv = 0; mode_wr = 0; irq_ack = 0;
        @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b1;
        m_ph = 0; m_cnt = 0; m_pend = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R1: reset state
        check("R1 phase after reset", phase, 0);
        check("R1 pending after reset", irq_pending, 0);
        check("R1 vblank after reset", vblank, 1);

        // R7 RESUME to LIVE below inactive start; R1 zero counter raises at once
        mode5_sel = 1; mode4_sel = 0; inactive_start = 9'd8; irq_reload = 8'd3;
        step(0, 2, 1, 0);
        check("R7 resume live", phase, 2);
        step(1, 3, 0, 0);
        check("R1 zero counter raises", irq_pending, 1);
        step(0, 3, 0, 1);
        check("R11 ack clears", irq_pending, 0);
        // R10 cadence: reload 3 -> raise on 4th LIVE line
        step(1, 4, 0, 0); step(1, 5, 0, 0); step(1, 6, 0, 0);
        check("R10 no raise before zero", irq_pending, 0);
        step(1, 7, 0, 0);
        check("R10 raise at zero", irq_pending, 1);
        step(0, 7, 0, 1);
        // R4 RETIRE
        step(1, 8, 0, 0);
        check("R4 retire at inactive start", phase, 0);
        // R9 reload while IDLE
        irq_reload = 8'd1;
        step(1, 9, 0, 0);
        step(1, 9'h1FE, 0, 0);
        check("R5 no arm on 1FE", phase, 0);
        step(1, 9'h1FF, 0, 0);
        check("R5 arm mode5 on 1FF", phase, 1);
        step(1, 0, 0, 0);
        check("R3 promote", phase, 2);
        check("R9 reloaded count not expired", irq_pending, 0);
        step(1, 1, 0, 1);
        check("R9 raise after reload+1 lines", irq_pending, 1);
        check("R11 raise wins over ack", irq_pending, 1);
        // R8 display enable gating
        disp_en = 0; #1;
        check("R8 disabled active", disp_active, 0);
        check("R8 disabled vblank", vblank, 1);
        disp_en = 1; #1;
        check("R8 enabled active", disp_active, 1);
        // R6 KILL, then no arming with neither mode
        mode5_sel = 0; mode4_sel = 0;
        step(0, 2, 1, 1);
        check("R6 kill", phase, 0);
        step(1, 9'h1FF, 0, 0); step(1, 0, 0, 0);
        check("R5 neither mode never arms", phase, 0);
        // R7 mode4 at 1FF stays IDLE, mode5 at 1FF goes PREP
        mode4_sel = 1;
        step(1, 9'h1FF, 1, 0);
        check("R7 mode4 at 1FF stays idle", phase, 0);
        mode5_sel = 1;
        step(0, 9'h1FF, 1, 0);
        check("R7 mode5 at 1FF prep", phase, 1);
        // R5 mode4 arming on line 0
        mode5_sel = 0;
        step(1, 0, 0, 0);   // PREP -> LIVE
        step(1, 8, 0, 0);   // retire
        step(1, 0, 0, 0);
        check("R5 arm mode4 on line 0", phase, 1);
        // R12 coincident advance and write: advance first then resume
        step(1, 8, 0, 0);   // promote, line == start -> idle after retire rule
        check("R12 setup idle", phase, 0);
        step(1, 3, 1, 0);
        check("R12 adv then write resumes", phase, 2);
        step(1, 8, 1, 0);
        check("R12 retire then write stays idle", phase, 0);

        // Sweep: mode pairs x reload x inactive start, two frames each
        for (int mp = 0; mp < 4; mp++) begin
            for (int rl = 0; rl < 4; rl++) begin
                for (int is = 0; is < 2; is++) begin
                    do_reset();
                    mode5_sel = mp[0]; mode4_sel = mp[1];
                    irq_reload = rl[7:0];
                    inactive_start = (is == 0) ? 9'd4 : 9'd7;
                    step(0, 0, 1, 0);
                    for (int st = 0; st < 34; st++) begin
                        int pos = st % 17;
                        int ln = (pos < 11) ? pos + 1 : 9'h1FA + pos - 11 + 1;
                        if (ln > 9'h1FF) ln = 0;
                        disp_en = (st % 7) != 3;
                        step(1, ln, (st == 20), (st % 5) == 0);
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule